// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block takes bytes through a valid/ready input, holds them in a small internal queue, and sends each one on a single serial line as an asynchronous character frame. The frame shape is chosen at run time. A 2-bit length code gives 5 to 8 data bits. Parity can be switched on, with even or odd sense. A 2-bit stop code gives one, one and a half or two stop periods. Bit timing comes from a baud tick input that pulses at sixteen times the bit rate, so every bit is counted in ticks rather than in clock cycles.

Around the serialiser sit the line-level controls. An optional clear-to-send gate allows a new frame to begin only while the peer is ready, and it never cuts a frame short. A break request drives the line low once everything queued has gone out. Separate polarity controls invert the CTS input and the serial output. A synchronous flush empties the queue, and a busy output marks the span of each frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is at its idle level (txd equals the inverse of tx_invert), busy is low and in_ready is high.
- R2: Each frame is one low start bit followed by the data bits, least significant first. The count of data bits is set by fmt_len: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Before output inversion the line idles high.
- R3: With par_enable high, one parity bit follows the data bits. par_odd = 0 makes the number of ones over data and parity even, and par_odd = 1 makes it odd. Only the bits actually sent are counted.
- R4: Every start, data and parity bit lasts 16 baud ticks. The stop period lasts 16 ticks for fmt_stop 1 (and for the unused code 0), 24 ticks for 2, and 32 ticks for 3. The last tick of the stop period ends the frame.
- R5: While brk_req is high, queued bytes are still sent. Once the queue is empty and the line is idle, the line is held low (txd equals tx_invert) until brk_req falls.
- R6: With flow_enable high, a frame may start only while the effective CTS (cts xor cts_invert) is high. A frame that has started always runs to its end.
- R7: tx_invert inverts the serial output at every point of the frame and while idle. cts_invert inverts cts before the flow-control gate uses it.
- R8: A one-cycle q_flush removes every queued byte: in_ready is high on the next cycle and no discarded byte is ever sent.
- R9: The queue holds FIFO_DEPTH bytes. in_ready stays low while it is full, and bytes are sent in the order they were accepted.
- R10: The frame format (length, parity setting and stop length) is captured when a frame starts. Changing these controls mid-frame does not alter that frame.
- R11: busy is high from the start bit to the end of the stop period and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Byte to queue |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Queue can accept a byte |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| q_flush | input | 1 | Synchronous queue clear |
| fmt_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| par_enable | input | 1 | Insert a parity bit |
| par_odd | input | 1 | 0 even, 1 odd parity |
| fmt_stop | input | 2 | Stop length code (1: 1, 2: 1.5, 3: 2 bits) |
| flow_enable | input | 1 | Gate frame starts with CTS |
| cts | input | 1 | Clear-to-send from the peer |
| cts_invert | input | 1 | Invert cts before use |
| brk_req | input | 1 | Hold the line low after queued data |
| tx_invert | input | 1 | Invert the serial output |
| txd | output | 1 | Serial output |
| busy | output | 1 | A frame is in progress |

## Verification
Some rules can be checked on every cycle. The line must sit at its idle level whenever no frame or break is active. A frame may start only under a true effective CTS when gating is on. A frame may end only on a baud tick. A flush must reopen the input on the next cycle. A full queue must stay closed until something is popped or flushed. A finished drain under a break request must drive the line low. Other behaviour shows only in the bench's scenarios, where a scoreboard decodes each frame at the centre of every bit: bit order and values for each length code, the parity sense, exact stop lengths in ticks, ordering across a full queue, and format capture at the start of a frame.

// File: rtl/uft_pkg.sv
// Shared types and constants for the serial frame transmitter.
// Assumes bytes are at most 8 bits and length codes map 0..3 to 5..8 bits.
package uft_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } tx_state_t;

endpackage

// File: rtl/uft_fifo.sv
// Byte queue in front of the serialiser.
// A synchronous flush empties it, and a flush overrides a write in the
// same cycle. The read data is the head entry and is valid while not empty.
// Assumes DEPTH >= 2.
module uft_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             do_wr;
    logic             do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full && !flush;
    assign do_rd   = rd_en && !empty && !flush;
    assign rd_data = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer and occupancy update, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            end
            if (do_rd) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            end
            case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uft_shifter.sv
// Frame sequencer: start bit, 5..8 data bits LSB first, optional parity,
// then a 1, 1.5 or 2 bit stop period, all timed in baud ticks.
// The format is latched when the frame starts. The flow gate is checked
// only in idle. A break state holds the line low once the queue is drained.
// Assumes OVERSAMPLE is even so that half a bit is a whole tick count.
module uft_shifter
    import uft_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] q_data,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_code,
    input  logic              flow_en,
    input  logic              cts_ok,
    input  logic              brk,
    output logic              pop,
    output logic              line,
    output logic              busy
);
    localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);
    localparam logic [CNT_W-1:0] BIT_TICKS  = CNT_W'(OVERSAMPLE);
    localparam logic [CNT_W-1:0] HALF_TICKS = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2);
    localparam logic [CNT_W-1:0] TWO_TICKS  = CNT_W'(2 * OVERSAMPLE);

    tx_state_t         state;
    logic [CNT_W-1:0]  tick_cnt;
    logic [CNT_W-1:0]  stop_lim;
    logic [CNT_W-1:0]  bit_lim;
    logic [CNT_W-1:0]  stop_sel;
    logic [2:0]        bit_cnt;
    logic [2:0]        last_bit;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] data_mask;
    logic              par_on;
    logic              par_val;
    logic              start_ok;
    logic              bit_end;

    // Start permission: queued data and, if gated, an asserted CTS.
    assign start_ok  = (state == ST_IDLE) && !q_empty && (!flow_en || cts_ok);
    assign pop       = start_ok;
    assign data_mask = 8'hFF >> (2'd3 - len_code);
    assign bit_lim   = (state == ST_STOP) ? stop_lim : BIT_TICKS;
    assign bit_end   = tick && (tick_cnt == bit_lim - CNT_W'(1));
    assign busy      = (state == ST_START) || (state == ST_DATA) ||
                       (state == ST_PAR)   || (state == ST_STOP);

    // Stop length in ticks from the stop code; code 0 acts as one bit.
    always_comb begin
        case (stop_code)
            2'd2:    stop_sel = HALF_TICKS;
            2'd3:    stop_sel = TWO_TICKS;
            default: stop_sel = BIT_TICKS;
        endcase
    end

    // Line level before output inversion for each state.
    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_val;
            ST_BRK:   line = 1'b0;
            default:  line = 1'b1;
        endcase
    end

    // Frame sequencing, tick counting and format capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tick_cnt <= '0;
            bit_cnt  <= '0;
            last_bit <= '0;
            shreg    <= '0;
            par_on   <= 1'b0;
            par_val  <= 1'b0;
            stop_lim <= BIT_TICKS;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state    <= ST_START;
                        tick_cnt <= '0;
                        bit_cnt  <= '0;
                        shreg    <= q_data;
                        last_bit <= 3'd4 + {1'b0, len_code};
                        par_on   <= par_en;
                        par_val  <= (^(q_data & data_mask)) ^ par_odd;
                        stop_lim <= stop_sel;
                    end else if (brk && q_empty) begin
                        state <= ST_BRK;
                    end
                end
                ST_BRK: begin
                    if (!brk) begin
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    if (bit_end) begin
                        tick_cnt <= '0;
                        if (state == ST_START) begin
                            state <= ST_DATA;
                        end else if (state == ST_DATA) begin
                            shreg   <= shreg >> 1;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == last_bit) begin
                                state <= par_on ? ST_PAR : ST_STOP;
                            end
                        end else if (state == ST_PAR) begin
                            state <= ST_STOP;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (tick) begin
                        tick_cnt <= tick_cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Top of the serial frame transmitter: byte queue, frame sequencer and
// line polarity handling. The format controls are read when a frame
// starts. The CTS and output inversions are combinational at the pins.
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             baud_tick,
    input  logic             q_flush,
    input  logic [1:0]       fmt_len,
    input  logic             par_enable,
    input  logic             par_odd,
    input  logic [1:0]       fmt_stop,
    input  logic             flow_enable,
    input  logic             cts,
    input  logic             cts_invert,
    input  logic             brk_req,
    input  logic             tx_invert,
    output logic             txd,
    output logic             busy
);
    logic [BYTE_W-1:0] q_head;
    logic              q_empty;
    logic              q_full;
    logic              q_pop;
    logic              raw_line;
    logic              cts_eff;

    assign in_ready = !q_full;
    assign cts_eff  = cts ^ cts_invert;
    assign txd      = raw_line ^ tx_invert;

    uft_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (q_flush),
        .wr_en   (in_valid),
        .wr_data (in_data),
        .rd_en   (q_pop),
        .rd_data (q_head),
        .empty   (q_empty),
        .full    (q_full)
    );

    uft_shifter #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .q_empty   (q_empty),
        .q_data    (q_head),
        .len_code  (fmt_len),
        .par_en    (par_enable),
        .par_odd   (par_odd),
        .stop_code (fmt_stop),
        .flow_en   (flow_enable),
        .cts_ok    (cts_eff),
        .brk       (brk_req),
        .pop       (q_pop),
        .line      (raw_line),
        .busy      (busy)
    );

endmodule

// File: rtl/uft_chk.sv
// Temporal checks on the transmitter's pins and queue handshake.
// Attached to every instance of the top module by the bind below.
module uft_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic baud_tick,
    input logic q_flush,
    input logic flow_enable,
    input logic cts,
    input logic cts_invert,
    input logic brk_req,
    input logic tx_invert,
    input logic txd,
    input logic busy,
    input logic q_empty,
    input logic q_pop
);
    // R11
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk_req && !$past(brk_req)) |-> (txd != tx_invert));

    // R6
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(flow_enable)) |-> $past(cts ^ cts_invert));

    // R4
    tick_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(baud_tick));

    // R8
    flush_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_flush |=> in_ready);

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !q_flush && !q_pop) |=> !in_ready);

    // R5
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!busy && brk_req && q_empty) |-> (txd == tx_invert));

endmodule

bind uart_frame_tx uft_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .baud_tick   (baud_tick),
    .q_flush     (q_flush),
    .flow_enable (flow_enable),
    .cts         (cts),
    .cts_invert  (cts_invert),
    .brk_req     (brk_req),
    .tx_invert   (tx_invert),
    .txd         (txd),
    .busy        (busy),
    .q_empty     (q_empty),
    .q_pop       (q_pop)
);

// File: tb/uart_frame_tx_test.sv
// Scoreboard bench: the send task queues the expected frames, and a
// monitor decodes each frame at the centre of every bit and checks it.
module uart_frame_tx_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_ready;
    logic       baud_tick;
    logic       q_flush;
    logic [1:0] fmt_len;
    logic       par_enable;
    logic       par_odd;
    logic [1:0] fmt_stop;
    logic       flow_enable;
    logic       cts;
    logic       cts_invert;
    logic       brk_req;
    logic       tx_invert;
    logic       txd;
    logic       busy;

    always #4 clk = ~clk;

    uart_frame_tx uut (
        .clk (clk), .rst_n (rst_n), .in_data (in_data), .in_valid (in_valid),
        .in_ready (in_ready), .baud_tick (baud_tick), .q_flush (q_flush),
        .fmt_len (fmt_len), .par_enable (par_enable), .par_odd (par_odd),
        .fmt_stop (fmt_stop), .flow_enable (flow_enable), .cts (cts),
        .cts_invert (cts_invert), .brk_req (brk_req), .tx_invert (tx_invert),
        .txd (txd), .busy (busy)
    );

    typedef struct {
        logic [7:0] d;
        int         nb;
        bit         pe;
        bit         po;
        int         sc;
        string      tag;
    } frame_t;

    frame_t sb[$];
    frame_t cur;
    int     n_checks = 0;
    int     n_fail   = 0;
    bit     mon_on   = 1'b0;
    bit     bogus    = 1'b0;
    bit     done     = 1'b0;
    int     k        = 0;
    int     tdiv     = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Baud tick every third cycle, driven just after the clock edge.
    initial begin
        baud_tick = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            tdiv      = (tdiv == 2) ? 0 : tdiv + 1;
            baud_tick = (tdiv == 0);
        end
    end

    task automatic push_raw(input logic [7:0] d);
        bit r;
        @(posedge clk);
        #1;
        in_data  = d;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            r = in_ready;
            @(posedge clk);
        end while (!r);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        frame_t f;
        f.d   = d;
        f.nb  = 5 + int'(fmt_len);
        f.pe  = par_enable;
        f.po  = par_odd;
        f.sc  = int'(fmt_stop);
        f.tag = tag;
        sb.push_back(f);
        push_raw(d);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (sb.size() != 0 || mon_on);
    endtask

    task automatic wait_start();
        do @(negedge clk); while (!busy);
    endtask

    function automatic bit exp_bit(input frame_t f, input int i);
        logic [7:0] m;
        m = f.d & (8'hFF >> (8 - f.nb));
        if (i == 0) return 1'b0;
        if (i <= f.nb) return f.d[i-1];
        if (i == f.nb + 1 && f.pe) return (^m) ^ f.po;
        return 1'b1;
    endfunction

    function automatic int exp_len(input frame_t f);
        int s;
        s = (f.sc == 2) ? 24 : (f.sc == 3) ? 32 : 16;
        return 16 * (1 + f.nb + int'(f.pe)) + s;
    endfunction

    // Monitor: pops the expected frame on busy rising and samples bit centres.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (!mon_on && busy) begin
                mon_on = 1'b1;
                k      = 0;
                if (sb.size() == 0) begin
                    bogus = 1'b1;
                    check(1'b0, "R8", "frame started with nothing expected", 1, 0);
                end else begin
                    bogus = 1'b0;
                    cur   = sb.pop_front();
                end
            end
            if (mon_on) begin
                if (busy) begin
                    if (baud_tick) begin
                        if (k % 16 == 8 && !bogus) begin
                            check((txd ^ tx_invert) == exp_bit(cur, k / 16), cur.tag,
                                  $sformatf("bit %0d of frame 0x%02h", k / 16, cur.d),
                                  int'(txd ^ tx_invert), int'(exp_bit(cur, k / 16)));
                        end
                        k++;
                    end
                end else begin
                    if (!bogus) begin
                        check(k == exp_len(cur), cur.tag, "frame length in ticks (R4, R11)",
                              k, exp_len(cur));
                    end
                    mon_on = 1'b0;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_data = '0; in_valid = 1'b0; q_flush = 1'b0;
        fmt_len = 2'd3; par_enable = 1'b0; par_odd = 1'b0; fmt_stop = 2'd1;
        flow_enable = 1'b0; cts = 1'b0; cts_invert = 1'b0; brk_req = 1'b0;
        tx_invert = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1", "idle txd", int'(txd), 1);
        check(busy == 1'b0, "R1", "busy", int'(busy), 0);
        check(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);

        // R2 every length code
        for (int l = 0; l < 4; l++) begin
            fmt_len = 2'(l);
            send(8'hA5 ^ 8'(l * 17), "R2");
            wait_done();
        end

        // R3 parity sense, and parity over the sent bits only
        par_enable = 1'b1;
        par_odd = 1'b0; send(8'h07, "R3"); wait_done();
        par_odd = 1'b1; send(8'h07, "R3"); wait_done();
        fmt_len = 2'd0; par_odd = 1'b0; send(8'hFF, "R3"); wait_done();
        fmt_len = 2'd3; par_enable = 1'b0;

        // R4 stop lengths, including the unused code
        for (int s = 0; s < 4; s++) begin
            fmt_stop = 2'(s);
            send(8'h3C + 8'(s), "R4");
            wait_done();
        end
        fmt_stop = 2'd1;

        // R9 ordering through a full queue
        for (int b = 0; b < 6; b++) send(8'h10 + 8'(b * 37), "R9");
        wait_done();

        // R7 output inversion
        tx_invert = 1'b1;
        send(8'h96, "R7");
        wait_done();
        @(negedge clk);
        check(txd == 1'b0, "R7", "inverted idle txd", int'(txd), 0);
        tx_invert = 1'b0;

        // R6 flow gate blocks, then a started frame survives CTS falling
        flow_enable = 1'b1; cts = 1'b0;
        send(8'h5A, "R6");
        repeat (150) @(negedge clk);
        check(busy == 1'b0, "R6", "busy while CTS low", int'(busy), 0);
        cts = 1'b1;
        wait_start();
        cts = 1'b0;
        wait_done();

        // R7 CTS inversion: low cts becomes permission
        cts_invert = 1'b1;
        send(8'h81, "R7");
        wait_done();
        cts = 1'b1;
        send(8'h42, "R7");
        repeat (150) @(negedge clk);
        check(busy == 1'b0, "R7", "busy while inverted CTS blocks", int'(busy), 0);
        cts = 1'b0;
        wait_done();
        flow_enable = 1'b0; cts_invert = 1'b0;

        // R10 format changes mid-frame are ignored
        send(8'hC3, "R10");
        wait_start();
        fmt_len = 2'd0; par_enable = 1'b1; fmt_stop = 2'd3;
        wait_done();
        fmt_len = 2'd3; par_enable = 1'b0; fmt_stop = 2'd1;

        // R5 break after queued data
        send(8'h11, "R5");
        send(8'hEE, "R5");
        brk_req = 1'b1;
        wait_done();
        repeat (40) @(negedge clk);
        check(txd == 1'b0, "R5", "line during break", int'(txd), 0);
        check(busy == 1'b0, "R5", "busy during break", int'(busy), 0);
        brk_req = 1'b0;
        repeat (2) @(negedge clk);
        check(txd == 1'b1, "R5", "line after break", int'(txd), 1);

        // R8 flush discards a full queue
        flow_enable = 1'b1; cts = 1'b0;
        for (int b = 0; b < 4; b++) push_raw(8'hF0 + 8'(b));
        @(negedge clk);
        check(in_ready == 1'b0, "R9", "in_ready when full", int'(in_ready), 0);
        @(posedge clk);
        #1 q_flush = 1'b1;
        @(posedge clk);
        #1 q_flush = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R8", "in_ready after flush", int'(in_ready), 1);
        cts = 1'b1;
        repeat (300) @(negedge clk);
        check(busy == 1'b0, "R8", "busy after flush", int'(busy), 0);
        flow_enable = 1'b0;

        finish_run();
    end

endmodule